// File: doc/BRIEF.md
# SPI Pixel Stream Receiver

This block is an SPI slave that takes one frame of pixels from a host and turns it into single-cycle write transactions for a frame memory. The host sends four bytes per pixel: red, then green, then blue, then a pad byte that carries nothing. Each colour byte is cut down to its upper bits and packed into a narrower internal pixel word. Each packed word comes out with a write address that steps through the frame in raster order, starting at the top-left pixel and going left to right, row by row.

The host closes a frame by changing the level of the slave-select line. Either direction counts. Each change produces a one-cycle frame-done pulse, which a downstream buffer controller can use to swap display and fill buffers. The same change sends the write address back to zero and drops any partly received byte or pixel. All three SPI pins are sampled by the system clock through two-flop synchronisers, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_pix_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `wr_en` and `frame_done` are low. The first pixel completed after reset is written to address 0.
- R2: MOSI is sampled on each rising SCK edge, most significant bit first. Eight rising edges make one byte.
- R3: The bytes of a pixel are taken in the order red, green, blue, pad. The pad byte's value has no effect on the written data.
- R4: The channel widths come from `PIX_W`. Blue gets PIX_W/3 bits. Green gets one more bit when the remainder is at least 1. Red gets one more bit when the remainder is 2. With the default of 16, the written word is {R[7:3], G[7:2], B[7:3]} (RGB565, red in the top bits). Dropped low bits never affect the result.
- R5: Exactly one `wr_en` pulse, one cycle long, is issued per pixel, after its fourth (pad) byte. No write follows the first three bytes.
- R6: Write addresses start at 0 and increase by one per pixel. After address COLS*ROWS-1 they wrap to 0.
- R7: Every change of slave-select level, high-to-low or low-to-high, gives exactly one one-cycle `frame_done` pulse. With a steady slave-select no pulse is produced, including just after reset.
- R8: A slave-select change resets the next write address to 0 and discards any partly received byte or pixel.
- R9: `wr_en` and `frame_done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host (asynchronous) |
| spi_mosi | input | 1 | Serial data from host (asynchronous) |
| spi_ss | input | 1 | Slave select; each level change ends a frame |
| wr_en | output | 1 | One-cycle pixel write strobe |
| wr_addr | output | $clog2(COLS*ROWS) | Raster-order pixel address |
| wr_data | output | PIX_W | Packed pixel word |
| frame_done | output | 1 | One-cycle pulse per slave-select change |

## Verification
A wrong bit counter or byte slot shows up on the very next pixel as rotated or misplaced colour fields in `wr_data`. A lost or extra byte shows up as a write after only three bytes or a missing write after four. An address counter that fails to reset or wrap gives the wrong `wr_addr` on the first pixel after a slave-select change, or on the pixel after the last pixel of the frame. Faulty synchroniser edge detection shows up within a few cycles, as an extra or missing `frame_done` pulse, or as a `frame_done` pulse on the same cycle as a write.

// File: rtl/spi_pix_pkg.sv
package spi_pix_pkg;

    typedef enum logic [1:0] {
        SLOT_RED   = 2'd0,
        SLOT_GREEN = 2'd1,
        SLOT_BLUE  = 2'd2,
        SLOT_PAD   = 2'd3
    } slot_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_bytes_t;

    // blue gets the base share, green takes the first spare bit, red the second
    function automatic int blue_bits(input int pix_w);
        return pix_w / 3;
    endfunction

    function automatic int green_bits(input int pix_w);
        return pix_w / 3 + ((pix_w % 3) >= 1 ? 1 : 0);
    endfunction

    function automatic int red_bits(input int pix_w);
        return pix_w / 3 + ((pix_w % 3) == 2 ? 1 : 0);
    endfunction

endpackage

// File: rtl/spi_pix_sync.sv
module spi_pix_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic mosi_in,
    input  logic ss_in,
    output logic sck_rise,
    output logic mosi_bit,
    output logic ss_toggle
);
    localparam int LAST     = STAGES - 1;
    localparam int WARM_MAX = STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_MAX + 1);

    // bit 0 = sck, bit 1 = mosi, bit 2 = ss
    logic [2:0]        stage [STAGES];
    logic              sck_last;
    logic              ss_last;
    logic [WARM_W-1:0] warm;
    logic              armed;

    assign armed = (warm == WARM_W'(WARM_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
            sck_last  <= 1'b0;
            ss_last   <= 1'b0;
            warm      <= '0;
            sck_rise  <= 1'b0;
            ss_toggle <= 1'b0;
            mosi_bit  <= 1'b0;
        end else begin
            stage[0] <= {ss_in, mosi_in, sck_in};
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
            sck_last  <= stage[LAST][0];
            ss_last   <= stage[LAST][2];
            mosi_bit  <= stage[LAST][1];
            if (!armed) warm <= warm + 1'b1;
            sck_rise  <= armed && stage[LAST][0] && !sck_last;
            ss_toggle <= armed && (stage[LAST][2] != ss_last);
        end
    end

    // two rising edges can never be reported back to back
    assert_rise_spaced_R2: assert property (@(posedge clk) disable iff (rst)
        sck_rise |=> !sck_rise);

endmodule

// File: rtl/spi_pix_shift.sv
module spi_pix_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sck_rise,
    input  logic       mosi_bit,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    logic [2:0] bit_cnt;
    logic [6:0] acc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_cnt   <= '0;
            acc       <= '0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (sck_rise) begin
                acc     <= {acc[5:0], mosi_bit};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    byte_vld  <= 1'b1;
                    byte_data <= {acc, mosi_bit};
                end
            end
        end
    end

    // a byte only completes on a sampled rising edge
    assert_byte_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> $past(sck_rise));

endmodule

// File: rtl/spi_pix_packer.sv
module spi_pix_packer
    import spi_pix_pkg::*;
#(
    parameter int COLS  = 64,
    parameter int ROWS  = 32,
    parameter int PIX_W = 16,
    localparam int PIXELS = COLS * ROWS,
    localparam int ADDR_W = $clog2(PIXELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data
);
    localparam int RW = red_bits(PIX_W);
    localparam int GW = green_bits(PIX_W);
    localparam int BW = blue_bits(PIX_W);

    slot_e             slot;
    rgb_bytes_t        held;
    logic [ADDR_W-1:0] addr_cnt;
    logic [PIX_W-1:0]  packed_px;

    assign packed_px = {held.red[7 -: RW], held.green[7 -: GW], held.blue[7 -: BW]};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot     <= SLOT_RED;
            held     <= '0;
            addr_cnt <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (byte_vld) begin
                unique case (slot)
                    SLOT_RED: begin
                        held.red <= byte_data;
                        slot     <= SLOT_GREEN;
                    end
                    SLOT_GREEN: begin
                        held.green <= byte_data;
                        slot       <= SLOT_BLUE;
                    end
                    SLOT_BLUE: begin
                        held.blue <= byte_data;
                        slot      <= SLOT_PAD;
                    end
                    SLOT_PAD: begin
                        wr_en    <= 1'b1;
                        wr_data  <= packed_px;
                        wr_addr  <= addr_cnt;
                        addr_cnt <= (addr_cnt == ADDR_W'(PIXELS - 1)) ? '0 : addr_cnt + 1'b1;
                        slot     <= SLOT_RED;
                    end
                    default: slot <= SLOT_RED;
                endcase
            end
        end
    end

    // a write is always the result of a byte arriving from the shifter
    assert_write_after_byte_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(byte_vld));

    // no write right after a frame boundary
    assert_no_write_after_clear_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(clear));

    // addresses stay inside the frame
    assert_addr_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_addr) < PIXELS));

endmodule

// File: rtl/spi_pix_rx.sv
module spi_pix_rx #(
    parameter int COLS  = 64,
    parameter int ROWS  = 32,
    parameter int PIX_W = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_ss,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [PIX_W-1:0]  wr_data,
    output logic              frame_done
);
    logic       sck_rise;
    logic       mosi_bit;
    logic       ss_toggle;
    logic       byte_vld;
    logic [7:0] byte_data;

    spi_pix_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sck_in    (spi_sck),
        .mosi_in   (spi_mosi),
        .ss_in     (spi_ss),
        .sck_rise  (sck_rise),
        .mosi_bit  (mosi_bit),
        .ss_toggle (ss_toggle)
    );

    spi_pix_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (ss_toggle),
        .sck_rise  (sck_rise),
        .mosi_bit  (mosi_bit),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    spi_pix_packer #(.COLS(COLS), .ROWS(ROWS), .PIX_W(PIX_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .clear     (ss_toggle),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) frame_done <= 1'b0;
        else     frame_done <= ss_toggle;
    end

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !wr_en);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

// File: tb/sim_spi_pix_rx.sv
module sim_spi_pix_rx;
    localparam int COLS   = 8;
    localparam int ROWS   = 4;
    localparam int PIXELS = COLS * ROWS;
    localparam int ADDR_W = $clog2(PIXELS);
    localparam int HALF   = 4;

    // {input R,G,B,pad ; expected RGB565}
    localparam logic [47:0] VEC [8] = '{
        {32'hFFFFFFAA, 16'hFFFF},
        {32'h000000FF, 16'h0000},
        {32'hFF000000, 16'hF800},
        {32'h00FF0000, 16'h07E0},
        {32'h0000FF00, 16'h001F},
        {32'h070307FF, 16'h0000},
        {32'h08040800, 16'h0821},
        {32'h80808055, 16'h8410}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic ss = 1'b0;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [15:0]       wr_data;
    logic              frame_done;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int fd_count = 0;
    int overlap = 0;
    logic [15:0]       last_data = '0;
    logic [ADDR_W-1:0] last_addr = '0;

    always #5 clk = ~clk;

    spi_pix_rx #(.COLS(COLS), .ROWS(ROWS), .PIX_W(16)) u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_ss(ss),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .frame_done(frame_done)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                wr_count++;
                last_data = wr_data;
                last_addr = wr_addr;
            end
            if (frame_done) fd_count++;
            if (wr_en && frame_done) overlap++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sck  = 1'b0;
        mosi = b;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_pixel(input logic [31:0] v);
        for (int i = 3; i >= 0; i--) send_byte(v[i*8 +: 8]);
        settle();
    endtask

    task automatic flip_ss();
        sck = 1'b0;
        @(negedge clk);
        ss = ~ss;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int wc;
        int fc;
        // R1: outputs quiet during reset
        repeat (5) @(negedge clk);
        check("R1 wr_en in reset", 32'(wr_en), 0);
        check("R1 frame_done in reset", 32'(frame_done), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 wr_en after reset", 32'(wr_en), 0);
        settle();
        check("R7 no spurious frame_done", 32'(fd_count), 0);

        // R2 R3 R4 R6: table of pixels, addresses 0..7
        for (int i = 0; i < 8; i++) begin
            wc = wr_count;
            send_pixel(VEC[i][47:16]);
            check("R5 one write per pixel", 32'(wr_count), 32'(wc + 1));
            check("R4 R3 R2 packed data", 32'(last_data), 32'(VEC[i][15:0]));
            check("R6 raster address", 32'(last_addr), 32'(i));
        end

        // R5: no write after three bytes, write after the pad byte
        wc = wr_count;
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'hFF);
        settle();
        check("R5 no write after 3 bytes", 32'(wr_count), 32'(wc));
        send_byte(8'h12);
        settle();
        check("R5 write after pad", 32'(wr_count), 32'(wc + 1));
        check("R4 magenta", 32'(last_data), 32'hF81F);
        check("R6 address 8", 32'(last_addr), 8);

        // R7 R8: partial pixel and partial byte discarded on ss rise
        fc = fd_count;
        send_byte(8'h00); send_byte(8'h00);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        flip_ss();
        check("R7 pulse on ss rise", 32'(fd_count), 32'(fc + 1));
        send_pixel(32'hFF000000);
        check("R8 address reset", 32'(last_addr), 0);
        check("R8 partial data dropped", 32'(last_data), 32'hF800);

        // R6: fill the rest of the frame and wrap
        for (int i = 1; i < PIXELS; i++) send_pixel({8'(i * 8), 8'(i * 4), 8'(i * 8), 8'h00});
        check("R6 last address", 32'(last_addr), 32'(PIXELS - 1));
        check("R4 last data", 32'(last_data), 32'({5'(PIXELS - 1), 6'(PIXELS - 1), 5'(PIXELS - 1)}));
        send_pixel(32'h0000FF00);
        check("R6 wrap to zero", 32'(last_addr), 0);

        // R7: falling ss also ends a frame
        fc = fd_count;
        flip_ss();
        check("R7 pulse on ss fall", 32'(fd_count), 32'(fc + 1));
        send_pixel(32'h00FF0000);
        check("R8 address after fall", 32'(last_addr), 0);
        check("R4 green after fall", 32'(last_data), 32'h07E0);

        // R1: reset mid-pixel restarts at address 0
        send_byte(8'hAA); send_byte(8'h55);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        send_pixel(32'h08040800);
        check("R1 address after reset", 32'(last_addr), 0);
        check("R1 data after reset", 32'(last_data), 32'h0821);

        check("R9 no overlap", 32'(overlap), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule